// File: doc/BRIEF.md
# Non-Temporal Line Combining Buffer

This block gathers non-temporal stores on their way to memory. Each store carries a line address, a chunk index that selects one 16-byte slice of a 64-byte line, a byte-enable mask and 16 bytes of data. The buffer keeps a few entries. Each entry holds one line, its line address and a 64-bit mask that marks which bytes stores have written. A store to a line that already has an entry merges into that entry. A store to a new line takes a free entry.

An entry whose mask becomes all ones is written to memory as one whole-line write, and the old line is never read. An entry that must leave while only partly written first reads the line from memory. The fetched bytes fill the holes, and the merged line is then written. After each accepted memory write, an update notice carries the same line address and data, so that a main cache holding the line can refresh its copy. A cache that does not hold the line ignores the notice. When a new line arrives and no entry is free, the oldest entry is evicted. A flush request drains every entry, oldest first, and reports completion.

Top module: `ncwb_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `mr_valid`, `mw_valid`, `upd_valid` and `flush_done` are low and `st_ready` is high.
- R2: Stores that fill all four chunks of one line, in any chunk order, produce exactly one write of that line carrying all the stored bytes.
- R3: A line completed by stores is written without any read request.
- R4: A partly written line that is drained produces one read request for its line address, then one write of that line. In that write, bytes written by stores override the fetched bytes and the other bytes equal the fetched data.
- R5: In the cycle after each accepted write (`mw_valid` and `mw_ready` high), `upd_valid` is high, with `upd_addr` and `upd_data` equal to the written address and line. `upd_valid` is low at all other times.
- R6: A store to a new line while every entry is occupied is held back. The oldest entry is drained first, and the store is then accepted.
- R7: After a one-cycle `flush_req`, `st_ready` stays low. Every occupied entry is drained oldest first, and `flush_done` is high for one cycle after the last write, with nothing left to write.
- R8: A store whose line matches an entry that is being drained is held (`st_ready` low) until that entry's write is accepted. It then starts a fresh entry.
- R9: Bit k of `st_be` enables byte k of the chunk, taken from `st_data[8k+7:8k]`. Chunk c covers line bytes 16c to 16c+15, and line byte b sits at bits 8b+7:8b of the line data. Bytes with a low enable keep their earlier value, and a later store to a byte replaces an earlier one.
- R10: `mr_valid` and `mw_valid` are never high in the same cycle.
- R11: Once raised, `mw_valid` and `mr_valid` stay high, with an unchanged address, until their ready input is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_line | input | LINE_AW (26) | Line address of the store |
| st_chunk | input | 2 | Chunk index within the line |
| st_be | input | 16 | Byte enables for the chunk |
| st_data | input | 128 | Chunk data |
| flush_req | input | 1 | Start draining all entries |
| flush_done | output | 1 | One-cycle pulse: flush finished, buffer empty |
| mr_valid | output | 1 | Line read request |
| mr_ready | input | 1 | Read request taken |
| mr_addr | output | LINE_AW (26) | Line address to read |
| mr_rsp_valid | input | 1 | Read data returned |
| mr_rsp_data | input | 512 | Returned line |
| mw_valid | output | 1 | Line write request |
| mw_ready | input | 1 | Write request taken |
| mw_addr | output | LINE_AW (26) | Line address to write |
| mw_data | output | 512 | Whole line to write |
| upd_valid | output | 1 | Update notice for the main cache |
| upd_addr | output | LINE_AW (26) | Line address of the notice |
| upd_data | output | 512 | New line contents |

## Verification
A wrong byte mask is visible at the memory port within a few cycles. If the mask reads full too early, a whole-line write goes out with stale bytes and no read in front of it. If it never reaches full, no write appears until an eviction or a flush, and a read then shows up where none should.

A broken age order shows at the next eviction or flush, where lines reach memory in the wrong sequence. A lost busy mark shows as a store that is accepted during a drain and whose bytes never reach any later write.

// File: rtl/ncwb_pkg.sv
package ncwb_pkg;

    // Drain engine states: one line moves to memory at a time
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_RDREQ  = 2'd1,
        ENG_RDWAIT = 2'd2,
        ENG_WRITE  = 2'd3
    } eng_e;

endpackage

// File: rtl/ncwb_match.sv
// Parallel line-address compare across all entries, plus the lowest free slot
module ncwb_match #(
    parameter int NUM_ENT = 4,
    parameter int LINE_AW = 26,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0]              vld,
    input  logic [NUM_ENT-1:0][LINE_AW-1:0] tag,
    input  logic [LINE_AW-1:0]              key,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx,
    output logic                            free_any,
    output logic [IDX_W-1:0]                free_idx
);

    logic [NUM_ENT-1:0] eq;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tag[g] == key);
    end

    always_comb begin
        hit      = |eq;
        free_any = ~&vld;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (eq[i])   hit_idx  = IDX_W'(i);
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ncwb_age_pick.sv
// Picks the oldest occupied entry (highest rank) and the lowest complete entry
module ncwb_age_pick #(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0]            vld,
    input  logic [NUM_ENT-1:0][IDX_W-1:0] age,
    input  logic [NUM_ENT-1:0]            full,
    output logic [IDX_W-1:0]              old_idx,
    output logic                          full_any,
    output logic [IDX_W-1:0]              full_idx
);

    logic [IDX_W-1:0] best;

    always_comb begin
        best     = '0;
        old_idx  = '0;
        full_any = |full;
        full_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (vld[i] && (age[i] >= best)) begin
                best    = age[i];
                old_idx = IDX_W'(i);
            end
        end
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (full[i]) full_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ncwb_top.sv
module ncwb_top
    import ncwb_pkg::*;
#(
    parameter int NUM_ENT     = 4,
    parameter int LINE_AW     = 26,
    parameter int LINE_BYTES  = 64,
    parameter int CHUNK_BYTES = 16,
    localparam int LINE_BITS  = LINE_BYTES * 8,
    localparam int CHUNK_BITS = CHUNK_BYTES * 8,
    localparam int CHUNKS     = LINE_BYTES / CHUNK_BYTES,
    localparam int CIDX_W     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam int IDX_W      = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [LINE_AW-1:0]     st_line,
    input  logic [CIDX_W-1:0]      st_chunk,
    input  logic [CHUNK_BYTES-1:0] st_be,
    input  logic [CHUNK_BITS-1:0]  st_data,
    input  logic                   flush_req,
    output logic                   flush_done,
    output logic                   mr_valid,
    input  logic                   mr_ready,
    output logic [LINE_AW-1:0]     mr_addr,
    input  logic                   mr_rsp_valid,
    input  logic [LINE_BITS-1:0]   mr_rsp_data,
    output logic                   mw_valid,
    input  logic                   mw_ready,
    output logic [LINE_AW-1:0]     mw_addr,
    output logic [LINE_BITS-1:0]   mw_data,
    output logic                   upd_valid,
    output logic [LINE_AW-1:0]     upd_addr,
    output logic [LINE_BITS-1:0]   upd_data
);

    typedef struct packed {
        logic [NUM_ENT-1:0]                 vld;
        logic [NUM_ENT-1:0][LINE_AW-1:0]    tag;
        logic [NUM_ENT-1:0][LINE_BYTES-1:0] bmask;
        logic [NUM_ENT-1:0][LINE_BITS-1:0]  line;
        logic [NUM_ENT-1:0][IDX_W-1:0]      age;   // 0 = newest
        eng_e                               eng;
        logic [IDX_W-1:0]                   vic;
        logic                               flush;
        logic                               upd_v;
        logic [LINE_AW-1:0]                 upd_a;
        logic [LINE_BITS-1:0]               upd_d;
    } state_t;

    state_t q, d;

    // lookup and age selection
    logic               hit, free_any, full_any;
    logic [IDX_W-1:0]   hit_idx, free_idx, old_idx, full_idx;
    logic [NUM_ENT-1:0] full_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_full
        assign full_vec[g] = q.vld[g] && (&q.bmask[g]);
    end

    ncwb_match #(.NUM_ENT(NUM_ENT), .LINE_AW(LINE_AW)) u_match (
        .vld      (q.vld),
        .tag      (q.tag),
        .key      (st_line),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    ncwb_age_pick #(.NUM_ENT(NUM_ENT)) u_age (
        .vld      (q.vld),
        .age      (q.age),
        .full     (full_vec),
        .old_idx  (old_idx),
        .full_any (full_any),
        .full_idx (full_idx)
    );

    // combinational helpers
    logic               eng_idle, evict_need, pick_old, start, accept, alloc, w_fire;
    logic [IDX_W-1:0]   sel, tgt;
    logic [NUM_ENT-1:0] busy;
    int                 base;

    always_comb begin
        d       = q;
        d.upd_v = 1'b0;

        // choose what the drain engine works on next
        eng_idle   = (q.eng == ENG_IDLE);
        evict_need = st_valid && !q.flush && !hit && !free_any;
        pick_old   = q.flush || evict_need;
        start      = eng_idle && (pick_old ? (|q.vld) : full_any);
        sel        = pick_old ? old_idx : full_idx;

        // an entry under drain, or chosen this cycle, takes no stores
        for (int i = 0; i < NUM_ENT; i++) begin
            busy[i] = (!eng_idle && (q.vic == IDX_W'(i)))
                   || (start && (sel == IDX_W'(i)));
        end

        st_ready   = !q.flush && (hit ? !busy[hit_idx] : free_any);
        accept     = st_valid && st_ready;
        alloc      = accept && !hit;
        tgt        = hit ? hit_idx : free_idx;
        w_fire     = (q.eng == ENG_WRITE) && mw_ready;
        flush_done = q.flush && !(|q.vld) && eng_idle;
        base       = int'(st_chunk) * CHUNK_BYTES;

        // age ranks stay dense: 0 .. occupied-1
        for (int i = 0; i < NUM_ENT; i++) begin
            if (q.vld[i]) begin
                d.age[i] = q.age[i] + IDX_W'(alloc)
                         - IDX_W'(w_fire && (q.age[i] > q.age[q.vic]));
            end
        end

        // store accept: allocate on miss, then merge enabled bytes
        if (alloc) begin
            d.vld[tgt]   = 1'b1;
            d.tag[tgt]   = st_line;
            d.bmask[tgt] = '0;
            d.age[tgt]   = '0;
        end
        if (accept) begin
            for (int c = 0; c < CHUNK_BYTES; c++) begin
                if (st_be[c]) begin
                    d.line[tgt][(base + c) * 8 +: 8] = st_data[c * 8 +: 8];
                    d.bmask[tgt][base + c]           = 1'b1;
                end
            end
        end

        // drain engine
        case (q.eng)
            ENG_IDLE: begin
                if (start) begin
                    d.vic = sel;
                    d.eng = (&q.bmask[sel]) ? ENG_WRITE : ENG_RDREQ;
                end
            end
            ENG_RDREQ: begin
                if (mr_ready) d.eng = ENG_RDWAIT;
            end
            ENG_RDWAIT: begin
                if (mr_rsp_valid) begin
                    for (int b = 0; b < LINE_BYTES; b++) begin
                        if (!q.bmask[q.vic][b]) begin
                            d.line[q.vic][b * 8 +: 8] = mr_rsp_data[b * 8 +: 8];
                        end
                    end
                    d.bmask[q.vic] = '1;
                    d.eng          = ENG_WRITE;
                end
            end
            ENG_WRITE: begin
                if (mw_ready) begin
                    d.vld[q.vic]   = 1'b0;
                    d.bmask[q.vic] = '0;
                    d.upd_v        = 1'b1;
                    d.upd_a        = q.tag[q.vic];
                    d.upd_d        = q.line[q.vic];
                    d.eng          = ENG_IDLE;
                end
            end
            default: d.eng = ENG_IDLE;
        endcase

        if (flush_done) d.flush = 1'b0;
        if (flush_req)  d.flush = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mr_valid  = (q.eng == ENG_RDREQ);
    assign mr_addr   = q.tag[q.vic];
    assign mw_valid  = (q.eng == ENG_WRITE);
    assign mw_addr   = q.tag[q.vic];
    assign mw_data   = q.line[q.vic];
    assign upd_valid = q.upd_v;
    assign upd_addr  = q.upd_a;
    assign upd_data  = q.upd_d;

endmodule

// File: rtl/ncwb_checker.sv
module ncwb_checker #(
    parameter int LINE_AW = 26
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_req,
    input logic               flush_done,
    input logic               mr_valid,
    input logic               mr_ready,
    input logic [LINE_AW-1:0] mr_addr,
    input logic               mw_valid,
    input logic               mw_ready,
    input logic [LINE_AW-1:0] mw_addr,
    input logic               upd_valid,
    input logic [LINE_AW-1:0] upd_addr
);

    // R10: one memory transfer at a time
    a_r10_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        !(mr_valid && mw_valid));

    // R11: write request holds until taken
    a_r11_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr));

    // R11: read request holds until taken
    a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        mr_valid && !mr_ready |=> mr_valid && $stable(mr_addr));

    // R5: notice only right after an accepted write
    a_r5_update_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(mw_valid && mw_ready));

    // R5: notice names the written line
    a_r5_update_addr: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> upd_addr == $past(mw_addr));

    // R7: a second done cycle in a row only after a new request
    a_r7_done_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done && $past(flush_done) |-> $past(flush_req));

endmodule

bind ncwb_top ncwb_checker #(.LINE_AW(LINE_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .mr_valid   (mr_valid),
    .mr_ready   (mr_ready),
    .mr_addr    (mr_addr),
    .mw_valid   (mw_valid),
    .mw_ready   (mw_ready),
    .mw_addr    (mw_addr),
    .upd_valid  (upd_valid),
    .upd_addr   (upd_addr)
);

// File: tb/sim_ncwb_top.sv
module sim_ncwb_top;

    localparam int NE = 4, AW = 26, LB = 64, CB = 16;
    localparam int LBITS = LB * 8, CBITS = CB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             st_valid = 1'b0, st_ready;
    logic [AW-1:0]    st_line = '0;
    logic [1:0]       st_chunk = '0;
    logic [CB-1:0]    st_be = '0;
    logic [CBITS-1:0] st_data = '0;
    logic             flush_req = 1'b0, flush_done;
    logic             mr_valid, mr_ready = 1'b1;
    logic [AW-1:0]    mr_addr;
    logic             mr_rsp_valid = 1'b0;
    logic [LBITS-1:0] mr_rsp_data = '0;
    logic             mw_valid, mw_ready = 1'b1;
    logic [AW-1:0]    mw_addr;
    logic [LBITS-1:0] mw_data;
    logic             upd_valid;
    logic [AW-1:0]    upd_addr;
    logic [LBITS-1:0] upd_data;

    ncwb_top #(.NUM_ENT(NE), .LINE_AW(AW), .LINE_BYTES(LB), .CHUNK_BYTES(CB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
        .st_chunk(st_chunk), .st_be(st_be), .st_data(st_data),
        .flush_req(flush_req), .flush_done(flush_done),
        .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
        .mr_rsp_valid(mr_rsp_valid), .mr_rsp_data(mr_rsp_data),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard queues
    logic [AW-1:0]    exp_wa[$];
    logic [LBITS-1:0] exp_wd[$];
    logic [AW-1:0]    exp_ra[$];
    // bench-side picture of what stores have written per line
    logic [LBITS-1:0] mdl_d[int];
    logic [LB-1:0]    mdl_m[int];

    int rd_total = 0, wr_total = 0;
    bit overlap = 0;
    int rsp_delay = 0;
    bit rd_pending = 0;
    int rd_cnt = 0;
    logic [AW-1:0] rd_addr = '0;
    bit upd_exp = 0;
    logic [AW-1:0]    upd_ea;
    logic [LBITS-1:0] upd_ed;

    function automatic logic [LBITS-1:0] mem_line(input logic [AW-1:0] a);
        logic [LBITS-1:0] r;
        for (int w = 0; w < LBITS / 32; w++) r[w * 32 +: 32] = {a[15:0] ^ 16'h5A3C, 8'(w), 8'hC3};
        return r;
    endfunction

    function automatic logic [CBITS-1:0] pat(input logic [AW-1:0] a, input int c, input int salt);
        logic [CBITS-1:0] r;
        for (int w = 0; w < CBITS / 32; w++) r[w * 32 +: 32] = {a[11:0], 4'(c), 8'(salt), 8'(w + 1)};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [LBITS-1:0] act, input logic [LBITS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compare memory traffic and notices against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mw_valid && mr_valid) overlap = 1;
            if (upd_exp) begin
                check(upd_valid && upd_addr == upd_ea && upd_data == upd_ed, "R5",
                      "update notice", {upd_valid, upd_addr}, {1'b1, upd_ea});
            end else if (upd_valid) begin
                check(0, "R5", "notice without write", upd_addr, 0);
            end
            upd_exp = 0;
            if (mw_valid && mw_ready) begin
                wr_total++;
                if (exp_wa.size() == 0) begin
                    check(0, "R2", "unexpected write", mw_addr, 0);
                end else begin
                    logic [AW-1:0] ea;
                    logic [LBITS-1:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    check(mw_addr == ea, "R6", "write order/address", mw_addr, ea);
                    check(mw_data == ed, "R9", "written line (R2 R4)", mw_data, ed);
                end
                upd_exp = 1;
                upd_ea  = mw_addr;
                upd_ed  = mw_data;
            end
            if (mr_valid && mr_ready) begin
                rd_total++;
                if (exp_ra.size() == 0) begin
                    check(0, "R3", "unexpected read", mr_addr, 0);
                end else begin
                    logic [AW-1:0] ra;
                    ra = exp_ra.pop_front();
                    check(mr_addr == ra, "R4", "read address", mr_addr, ra);
                end
                rd_pending = 1;
                rd_addr    = mr_addr;
                rd_cnt     = 0;
            end
        end
    end

    // memory read responder
    initial begin
        forever begin
            @(posedge clk);
            #2;
            mr_rsp_valid = 1'b0;
            if (rd_pending) begin
                if (rd_cnt >= rsp_delay) begin
                    mr_rsp_valid = 1'b1;
                    mr_rsp_data  = mem_line(rd_addr);
                    rd_pending   = 0;
                end else begin
                    rd_cnt++;
                end
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input int c, input logic [CB-1:0] be,
                            input logic [CBITS-1:0] dat, output int waits);
        logic [LBITS-1:0] ld;
        logic [LB-1:0]    lm;
        @(posedge clk);
        #2;
        st_valid = 1'b1; st_line = a; st_chunk = 2'(c); st_be = be; st_data = dat;
        waits = 0;
        @(negedge clk);
        while (!st_ready) begin
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        #2;
        st_valid = 1'b0;
        if (mdl_m.exists(int'(a))) begin
            ld = mdl_d[int'(a)];
            lm = mdl_m[int'(a)];
        end else begin
            ld = '0;
            lm = '0;
        end
        for (int b = 0; b < CB; b++) begin
            if (be[b]) begin
                ld[(c * CB + b) * 8 +: 8] = dat[b * 8 +: 8];
                lm[c * CB + b] = 1'b1;
            end
        end
        if (&lm) begin
            exp_wa.push_back(a);
            exp_wd.push_back(ld);
            mdl_d.delete(int'(a));
            mdl_m.delete(int'(a));
        end else begin
            mdl_d[int'(a)] = ld;
            mdl_m[int'(a)] = lm;
        end
    endtask

    task automatic expect_drain(input logic [AW-1:0] a);
        logic [LBITS-1:0] r;
        r = mem_line(a);
        for (int b = 0; b < LB; b++) begin
            if (mdl_m[int'(a)][b]) r[b * 8 +: 8] = mdl_d[int'(a)][b * 8 +: 8];
        end
        exp_ra.push_back(a);
        exp_wa.push_back(a);
        exp_wd.push_back(r);
        mdl_d.delete(int'(a));
        mdl_m.delete(int'(a));
    endtask

    task automatic do_flush();
        int n;
        @(posedge clk); #2; flush_req = 1'b1;
        @(posedge clk); #2; flush_req = 1'b0;
        @(negedge clk);
        check(!st_ready, "R7", "st_ready during flush", st_ready, 0);
        n = 0;
        while (!flush_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(flush_done, "R7", "flush_done seen", flush_done, 1);
        check(exp_wa.size() == 0, "R7", "writes left at done", exp_wa.size(), 0);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while ((exp_wa.size() != 0 || mw_valid || mr_valid) && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, r0, w0;
        logic [AW-1:0] ln;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(st_ready == 1 && !mw_valid && !mr_valid && !upd_valid && !flush_done,
              "R1", "held reset outputs", {st_ready, mw_valid, mr_valid, upd_valid, flush_done}, 5'b10000);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        check(st_ready == 1, "R1", "st_ready after reset", st_ready, 1);
        check(!mw_valid && !mr_valid, "R1", "no memory request", {mw_valid, mr_valid}, 0);
        check(!upd_valid && !flush_done, "R1", "no notice or done", {upd_valid, flush_done}, 0);

        // R2 R3: full line in chunk order
        r0 = rd_total; w0 = wr_total;
        ln = 26'h0000040;
        for (int c = 0; c < 4; c++) do_store(ln, c, 16'hFFFF, pat(ln, c, 1), w);
        wait_idle();
        check(rd_total == r0, "R3", "reads for full line", rd_total - r0, 0);
        check(wr_total == w0 + 1, "R2", "one write per line", wr_total - w0, 1);

        // R9 R2 R3: scrambled chunk order with byte overrides
        r0 = rd_total;
        ln = 26'h0000100;
        do_store(ln, 2, 16'hFFFF, pat(ln, 2, 2), w);
        do_store(ln, 0, 16'h00FF, pat(ln, 0, 3), w);
        do_store(ln, 0, 16'hFF00, pat(ln, 0, 4), w);
        do_store(ln, 0, 16'h000F, pat(ln, 0, 5), w);
        do_store(ln, 3, 16'hFFFF, pat(ln, 3, 6), w);
        do_store(ln, 1, 16'hFFFF, pat(ln, 1, 7), w);
        wait_idle();
        check(rd_total == r0, "R3", "reads for merged line", rd_total - r0, 0);

        // R4 R7: partial lines drained by flush, oldest first
        rsp_delay = 0;
        do_store(26'h0000200, 1, 16'h00F0, pat(26'h200, 1, 8), w);
        do_store(26'h0000201, 0, 16'hFFFF, pat(26'h201, 0, 9), w);
        do_store(26'h0000201, 3, 16'h8001, pat(26'h201, 3, 10), w);
        expect_drain(26'h0000200);
        expect_drain(26'h0000201);
        do_flush();

        // R6: eviction of the oldest entry
        rsp_delay = 3;
        for (int i = 0; i < 4; i++) do_store(26'h0000300 + 26'(i), i, 16'h3C3C, pat(26'h300, i, 11), w);
        expect_drain(26'h0000300);
        do_store(26'h0000304, 0, 16'hFFFF, pat(26'h304, 0, 12), w);
        check(w >= 1, "R6", "store held for eviction", w, 1);
        for (int i = 1; i < 5; i++) expect_drain(26'h0000300 + 26'(i));
        do_flush();

        // R8 R11: store to a line whose write is held back
        rsp_delay = 1;
        ln = 26'h0000500;
        @(posedge clk); #2; mw_ready = 1'b0;
        for (int c = 0; c < 4; c++) do_store(ln, c, 16'hFFFF, pat(ln, c, 13), w);
        repeat (3) @(negedge clk);
        check(mw_valid && mw_addr == ln, "R11", "write held without ready", {mw_valid, mw_addr}, {1'b1, ln});
        fork
            begin
                repeat (10) @(posedge clk);
                #2;
                mw_ready = 1'b1;
            end
        join_none
        do_store(ln, 1, 16'h0FF0, pat(ln, 1, 14), w);
        check(w >= 5, "R8", "stall cycles on busy line", w, 5);
        expect_drain(ln);
        do_flush();

        check(!overlap, "R10", "read and write together", overlap, 0);
        check(exp_wa.size() == 0 && exp_ra.size() == 0, "R4", "leftover expectations",
              exp_wa.size() + exp_ra.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule